// File: doc/BRIEF.md
# Next-Fit Contiguous Page-Run Allocator

This block hands out runs of adjacent pages from a pool of `NUM_PAGES` pages, tracking occupancy with one bit per page. A client asks for a run of a given length and receives the first page of the run, or a failure indication. Runs are returned by naming their first page and length. The search is next-fit: it starts where the previous successful allocation ended. If no run fits between that point and the top of the pool, the search restarts once from page zero.

Reusing pages may leave stale translations elsewhere in the system. The block therefore keeps a single deferred-invalidate flag. It raises the flag when the next-fit pointer wraps or when a search has to restart. A separate command turns a raised flag into a one-cycle invalidate pulse. A strict mode raises the flag after every allocation. The lowest `RSV_PAGES` pages are held back permanently.

A small combinational helper sits beside the allocator. It turns a byte offset and a byte length into the number of pages the buffer spans.

Top module: `page_run_alloc`

## Requirements
- R1: After reset, pages 0 to RSV_PAGES-1 are occupied and all other pages are free. The next-fit pointer is 0, the invalidate flag is clear, and all three ready outputs are high.
- R2: An allocation of size S scans upward from the next-fit pointer. It returns the lowest offset at or above the pointer where S consecutive free pages lie wholly below NUM_PAGES.
- R3: On success, `rsp_valid` is high for one cycle with `rsp_fail`=0 and the run's first page on `rsp_offset`. The run's pages become occupied, and the pointer moves to offset+S.
- R4: If offset+S is greater than or equal to NUM_PAGES, the pointer becomes 0 and the invalidate flag is raised.
- R5: If the first pass finds no run, the flag is raised and the scan repeats once from page 0. A run found there is returned as in R3.
- R6: If neither pass finds a run, or S is 0, the response has `rsp_fail`=1 and `rsp_offset` all ones. No page changes state and the pointer is unchanged.
- R7: While `full_flush` is high, every completed allocation raises the flag, whether it succeeds or fails.
- R8: A free command clears the occupancy of pages in [offset, offset+size) that are at or above RSV_PAGES. Reserved pages stay occupied.
- R9: An accepted flush command produces `flush_pulse` high for exactly one cycle, one cycle after acceptance, only if the flag was raised. The flag is then clear.
- R10: A command is accepted only while no allocation scan is running, with priority allocate > free > flush. The scan examines one page per clock. A response arrives k clock edges after the accepting edge, where k is the number of pages examined, and all readies are low until then.
- R11: `calc_pages` = ceil((calc_off + calc_len) / 2^PAGE_SHIFT). The default page is 4 KiB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_flush | input | 1 | Strict mode: every allocation raises the invalidate flag |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Allocation request accepted this cycle |
| alloc_size | input | CNT_W | Pages requested |
| free_valid | input | 1 | Free request |
| free_ready | output | 1 | Free request accepted this cycle |
| free_offset | input | IDX_W | First page of run to release |
| free_size | input | CNT_W | Pages to release |
| flush_valid | input | 1 | Invalidate request |
| flush_ready | output | 1 | Invalidate request accepted this cycle |
| rsp_valid | output | 1 | Allocation response strobe |
| rsp_fail | output | 1 | Allocation found no run |
| rsp_offset | output | IDX_W | First page of granted run, all ones on failure |
| flush_pulse | output | 1 | One-cycle invalidate strobe |
| calc_off | input | PAGE_SHIFT | Byte offset of buffer within its page |
| calc_len | input | LEN_W | Buffer length in bytes |
| calc_pages | output | LEN_W-PAGE_SHIFT+2 | Pages spanned by the buffer |

## Verification
The bench builds the block with NUM_PAGES=48 and RSV_PAGES=32, which leaves 16 usable pages. A short command sequence can therefore reach pointer wrap, the restart from zero, full exhaustion, and fragmentation where a single stray free page cannot serve a request. Latency is exact because only 48 pages are scanned: the first allocation after reset takes a known count of edges. The helper keeps its default 4 KiB page and 20-bit length. The page-boundary straddles are exercised there.

// File: rtl/pra_pkg.sv
package pra_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } pra_state_e;
endpackage

// File: rtl/pra_page_count.sv
module pra_page_count #(
    parameter int PAGE_SHIFT = 12,
    parameter int LEN_W      = 20,
    localparam int SUM_W     = LEN_W + 2,
    localparam int PCNT_W    = SUM_W - PAGE_SHIFT
) (
    input  logic [PAGE_SHIFT-1:0] byte_off,
    input  logic [LEN_W-1:0]      byte_len,
    output logic [PCNT_W-1:0]     page_cnt
);
    localparam logic [SUM_W-1:0] ROUND_ADD = SUM_W'((1 << PAGE_SHIFT) - 1);

    logic [SUM_W-1:0] span_d;

    always_comb begin
        span_d   = SUM_W'(byte_off) + SUM_W'(byte_len) + ROUND_ADD;
        page_cnt = span_d[SUM_W-1:PAGE_SHIFT];
    end
endmodule

// File: rtl/pra_bitmap.sv
module pra_bitmap #(
    parameter int NUM_PAGES = 128,
    parameter int RSV_PAGES = 32,
    parameter int IDX_W     = $clog2(NUM_PAGES),
    parameter int CNT_W     = $clog2(NUM_PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] rng_start,
    input  logic [CNT_W-1:0] rng_len,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);
    localparam int CMP_W = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;
    localparam logic [NUM_PAGES-1:0] RST_MAP = {NUM_PAGES{1'b1}} >> (NUM_PAGES - RSV_PAGES);

    logic [NUM_PAGES-1:0] map_d, map_q;
    logic [NUM_PAGES-1:0] rng_mask;
    logic [CMP_W-1:0]     rng_lo, rng_hi;

    assign rng_lo = CMP_W'(rng_start);
    assign rng_hi = CMP_W'(rng_start) + CMP_W'(rng_len);

    for (genvar gi = 0; gi < NUM_PAGES; gi++) begin : g_mask
        assign rng_mask[gi] = (CMP_W'(gi) >= rng_lo) && (CMP_W'(gi) < rng_hi);
    end

    always_comb begin
        map_d = map_q;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (i < RSV_PAGES) begin
                map_d[i] = 1'b1;
            end else if (set_en && rng_mask[i]) begin
                map_d[i] = 1'b1;
            end else if (clr_en && rng_mask[i]) begin
                map_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= RST_MAP;
        else        map_q <= map_d;
    end

    assign rd_bit = map_q[rd_idx];

    // R3: a granted run must consist only of pages that were free
    assert_grant_on_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> ((map_q & rng_mask) == '0));

    // R2: a granted run lies wholly inside the pool
    assert_grant_in_pool_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> (rng_hi <= CMP_W'(NUM_PAGES)));

    // R8: reserved pages never become free
    assert_reserved_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (map_q & RST_MAP) == RST_MAP);

    // R10: occupancy never set and cleared in the same cycle
    assert_single_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en));
endmodule

// File: rtl/pra_ctrl.sv
module pra_ctrl
    import pra_pkg::*;
#(
    parameter int NUM_PAGES = 128,
    parameter int IDX_W     = $clog2(NUM_PAGES),
    parameter int CNT_W     = $clog2(NUM_PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_flush,
    input  logic             alloc_valid,
    input  logic [CNT_W-1:0] alloc_size,
    output logic             alloc_ready,
    input  logic             free_valid,
    input  logic [IDX_W-1:0] free_offset,
    input  logic [CNT_W-1:0] free_size,
    output logic             free_ready,
    input  logic             flush_valid,
    output logic             flush_ready,
    output logic             rsp_valid,
    output logic             rsp_fail,
    output logic [IDX_W-1:0] rsp_offset,
    output logic             flush_pulse,
    output logic             bm_set,
    output logic             bm_clr,
    output logic [IDX_W-1:0] bm_start,
    output logic [CNT_W-1:0] bm_len,
    output logic [IDX_W-1:0] bm_rd_idx,
    input  logic             bm_rd_bit
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [IDX_W-1:0] LAST_PG = IDX_W'(NUM_PAGES - 1);

    typedef struct packed {
        pra_state_e       st;
        logic             pass;
        logic [IDX_W-1:0] pos;
        logic [IDX_W-1:0] run_start;
        logic [CNT_W-1:0] run_len;
        logic [CNT_W-1:0] want;
        logic [IDX_W-1:0] ptr;
        logic             flag;
        logic             rsp_v;
        logic             rsp_f;
        logic [IDX_W-1:0] rsp_off;
        logic             pulse;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    logic             idle;
    logic [IDX_W-1:0] cand_start;
    logic [CNT_W-1:0] run_next;
    logic [SUM_W-1:0] end_pos;
    logic             wraps;
    logic             acc_alloc, acc_free, acc_flush;

    always_comb begin
        idle        = (ctl_q.st == ST_IDLE);
        alloc_ready = idle;
        free_ready  = idle && !alloc_valid;
        flush_ready = idle && !alloc_valid && !free_valid;
        acc_alloc   = alloc_valid && alloc_ready;
        acc_free    = free_valid && free_ready;
        acc_flush   = flush_valid && flush_ready;

        cand_start  = (ctl_q.run_len == '0) ? ctl_q.pos : ctl_q.run_start;
        run_next    = ctl_q.run_len + 1'b1;
        end_pos     = SUM_W'(cand_start) + SUM_W'(ctl_q.want);
        wraps       = (end_pos >= SUM_W'(NUM_PAGES));

        bm_set      = 1'b0;
        bm_clr      = 1'b0;
        bm_start    = free_offset;
        bm_len      = free_size;
        bm_rd_idx   = ctl_q.pos;

        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        ctl_d.pulse = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (acc_alloc) begin
                    if (alloc_size == '0) begin
                        ctl_d.rsp_v   = 1'b1;
                        ctl_d.rsp_f   = 1'b1;
                        ctl_d.rsp_off = '1;
                        if (full_flush) ctl_d.flag = 1'b1;
                    end else begin
                        ctl_d.st      = ST_SCAN;
                        ctl_d.want    = alloc_size;
                        ctl_d.pos     = ctl_q.ptr;
                        ctl_d.run_len = '0;
                        ctl_d.pass    = 1'b0;
                    end
                end else if (acc_free) begin
                    bm_clr = 1'b1;
                end else if (acc_flush) begin
                    ctl_d.pulse = ctl_q.flag;
                    ctl_d.flag  = 1'b0;
                end
            end
            ST_SCAN: begin
                if (!bm_rd_bit && (run_next == ctl_q.want)) begin
                    bm_set        = 1'b1;
                    bm_start      = cand_start;
                    bm_len        = ctl_q.want;
                    ctl_d.st      = ST_IDLE;
                    ctl_d.rsp_v   = 1'b1;
                    ctl_d.rsp_f   = 1'b0;
                    ctl_d.rsp_off = cand_start;
                    ctl_d.ptr     = wraps ? '0 : end_pos[IDX_W-1:0];
                    if (wraps || full_flush) ctl_d.flag = 1'b1;
                end else if (ctl_q.pos == LAST_PG) begin
                    if (!ctl_q.pass) begin
                        ctl_d.pass    = 1'b1;
                        ctl_d.pos     = '0;
                        ctl_d.run_len = '0;
                        ctl_d.flag    = 1'b1;
                    end else begin
                        ctl_d.st      = ST_IDLE;
                        ctl_d.rsp_v   = 1'b1;
                        ctl_d.rsp_f   = 1'b1;
                        ctl_d.rsp_off = '1;
                        if (full_flush) ctl_d.flag = 1'b1;
                    end
                end else begin
                    ctl_d.pos = ctl_q.pos + 1'b1;
                    if (bm_rd_bit) begin
                        ctl_d.run_len = '0;
                    end else begin
                        if (ctl_q.run_len == '0) ctl_d.run_start = ctl_q.pos;
                        ctl_d.run_len = run_next;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, pass: 1'b0, pos: '0, run_start: '0, run_len: '0,
                       want: '0, ptr: '0, flag: 1'b0, rsp_v: 1'b0, rsp_f: 1'b0,
                       rsp_off: '0, pulse: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid   = ctl_q.rsp_v;
    assign rsp_fail    = ctl_q.rsp_f;
    assign rsp_offset  = ctl_q.rsp_off;
    assign flush_pulse = ctl_q.pulse;

    // R10: no command is taken while a scan runs
    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SCAN) |-> (!alloc_ready && !free_ready && !flush_ready));

    // R10: at most one command accepted per cycle
    assert_one_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_alloc, acc_free, acc_flush}));

    // R6: failure reports the all-ones offset
    assert_fail_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fail) |-> (&rsp_offset));

    // R4: next-fit pointer stays inside the pool
    assert_ptr_in_pool_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.ptr <= LAST_PG);

    // R4: a grant leaving the pointer at zero has raised the flag
    assert_wrap_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fail && (ctl_q.ptr == '0)) |-> ctl_q.flag);

    // R9: a pulse only follows a raised flag, and leaves it clear
    assert_pulse_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> ($past(ctl_q.flag) && !ctl_q.flag));

    // R9: the pulse lasts a single cycle
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |=> !flush_pulse);

    // R7: strict mode leaves the flag raised after any completion
    assert_strict_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(full_flush)) |-> ctl_q.flag);

    // R3: the response strobe lasts a single cycle
    assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/page_run_alloc.sv
module page_run_alloc #(
    parameter int NUM_PAGES  = 128,
    parameter int RSV_PAGES  = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int LEN_W      = 20,
    localparam int IDX_W     = $clog2(NUM_PAGES),
    localparam int CNT_W     = $clog2(NUM_PAGES + 1),
    localparam int PCNT_W    = LEN_W - PAGE_SHIFT + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  full_flush,
    input  logic                  alloc_valid,
    output logic                  alloc_ready,
    input  logic [CNT_W-1:0]      alloc_size,
    input  logic                  free_valid,
    output logic                  free_ready,
    input  logic [IDX_W-1:0]      free_offset,
    input  logic [CNT_W-1:0]      free_size,
    input  logic                  flush_valid,
    output logic                  flush_ready,
    output logic                  rsp_valid,
    output logic                  rsp_fail,
    output logic [IDX_W-1:0]      rsp_offset,
    output logic                  flush_pulse,
    input  logic [PAGE_SHIFT-1:0] calc_off,
    input  logic [LEN_W-1:0]      calc_len,
    output logic [PCNT_W-1:0]     calc_pages
);
    logic             bm_set, bm_clr, bm_rd_bit;
    logic [IDX_W-1:0] bm_start, bm_rd_idx;
    logic [CNT_W-1:0] bm_len;

    pra_ctrl #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_flush (full_flush),
        .alloc_valid(alloc_valid),
        .alloc_size (alloc_size),
        .alloc_ready(alloc_ready),
        .free_valid (free_valid),
        .free_offset(free_offset),
        .free_size  (free_size),
        .free_ready (free_ready),
        .flush_valid(flush_valid),
        .flush_ready(flush_ready),
        .rsp_valid  (rsp_valid),
        .rsp_fail   (rsp_fail),
        .rsp_offset (rsp_offset),
        .flush_pulse(flush_pulse),
        .bm_set     (bm_set),
        .bm_clr     (bm_clr),
        .bm_start   (bm_start),
        .bm_len     (bm_len),
        .bm_rd_idx  (bm_rd_idx),
        .bm_rd_bit  (bm_rd_bit)
    );

    pra_bitmap #(.NUM_PAGES(NUM_PAGES), .RSV_PAGES(RSV_PAGES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (bm_set),
        .clr_en   (bm_clr),
        .rng_start(bm_start),
        .rng_len  (bm_len),
        .rd_idx   (bm_rd_idx),
        .rd_bit   (bm_rd_bit)
    );

    pra_page_count #(.PAGE_SHIFT(PAGE_SHIFT), .LEN_W(LEN_W)) u_pcnt (
        .byte_off(calc_off),
        .byte_len(calc_len),
        .page_cnt(calc_pages)
    );
endmodule

// File: tb/sim_page_run_alloc.sv
module sim_page_run_alloc;
    localparam int N      = 48;
    localparam int RSV    = 32;
    localparam int PS     = 12;
    localparam int LW     = 20;
    localparam int IDX_W  = $clog2(N);
    localparam int CNT_W  = $clog2(N + 1);
    localparam int PCNT_W = LW - PS + 2;
    localparam int FAILOFF = (1 << IDX_W) - 1;

    localparam logic [1:0] OP_ALLOC = 2'd0;
    localparam logic [1:0] OP_FREE  = 2'd1;
    localparam logic [1:0] OP_FLUSH = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       xfail;
        logic [7:0] xval;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{OP_FLUSH, 8'd0,  8'd0,  1'b0, 8'd0 },  // R1 flag clear after reset
        '{OP_ALLOC, 8'd4,  8'd0,  1'b0, 8'd32},  // R1 R2 first free page above reserve
        '{OP_ALLOC, 8'd8,  8'd0,  1'b0, 8'd36},  // R3 pointer advanced
        '{OP_ALLOC, 8'd4,  8'd0,  1'b0, 8'd44},  // R4 ends at pool top -> wrap
        '{OP_FLUSH, 8'd0,  8'd0,  1'b0, 8'd1 },  // R4 R9 pulse
        '{OP_FLUSH, 8'd0,  8'd0,  1'b0, 8'd0 },  // R9 flag consumed
        '{OP_FREE,  8'd36, 8'd8,  1'b0, 8'd0 },  // R8
        '{OP_ALLOC, 8'd2,  8'd0,  1'b0, 8'd36},  // R8 freed pages reused
        '{OP_FREE,  8'd32, 8'd4,  1'b0, 8'd0 },  // R8
        '{OP_ALLOC, 8'd5,  8'd0,  1'b0, 8'd38},  // R2 next-fit skips lower hole
        '{OP_FLUSH, 8'd0,  8'd0,  1'b0, 8'd0 },  // R4 no wrap, no flag
        '{OP_ALLOC, 8'd4,  8'd0,  1'b0, 8'd32},  // R5 retry from zero
        '{OP_FLUSH, 8'd0,  8'd0,  1'b0, 8'd1 },  // R5 retry raised flag
        '{OP_ALLOC, 8'd2,  8'd0,  1'b1, 8'd63},  // R6 only one lone free page
        '{OP_FLUSH, 8'd0,  8'd0,  1'b0, 8'd1 },  // R5 failed retry raised flag
        '{OP_FREE,  8'd0,  8'd40, 1'b0, 8'd0 },  // R8 range covers reserve
        '{OP_ALLOC, 8'd8,  8'd0,  1'b0, 8'd32},  // R8 reserve not handed out
        '{OP_FLUSH, 8'd0,  8'd0,  1'b0, 8'd1 },  // R5
        '{OP_ALLOC, 8'd0,  8'd0,  1'b1, 8'd63},  // R6 size zero
        '{OP_FLUSH, 8'd0,  8'd0,  1'b0, 8'd0 }   // R6 R7 no flag when mode off
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_flush = 1'b0;
    logic alloc_valid = 1'b0;
    logic [CNT_W-1:0] alloc_size = '0;
    logic free_valid = 1'b0;
    logic [IDX_W-1:0] free_offset = '0;
    logic [CNT_W-1:0] free_size = '0;
    logic flush_valid = 1'b0;
    logic [PS-1:0] calc_off = '0;
    logic [LW-1:0] calc_len = '0;
    logic alloc_ready, free_ready, flush_ready, rsp_valid, rsp_fail, flush_pulse;
    logic [IDX_W-1:0] rsp_offset;
    logic [PCNT_W-1:0] calc_pages;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    page_run_alloc #(.NUM_PAGES(N), .RSV_PAGES(RSV), .PAGE_SHIFT(PS), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .full_flush(full_flush),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_size(alloc_size),
        .free_valid(free_valid), .free_ready(free_ready), .free_offset(free_offset),
        .free_size(free_size), .flush_valid(flush_valid), .flush_ready(flush_ready),
        .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_offset(rsp_offset),
        .flush_pulse(flush_pulse), .calc_off(calc_off), .calc_len(calc_len),
        .calc_pages(calc_pages)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_alloc(input int size, input string req, input bit xfail, input int xoff,
                            input int xlat);
        int lat;
        int busy_bad;
        @(negedge clk);
        chk(alloc_ready == 1'b1, req, int'(alloc_ready), 1);
        alloc_valid = 1'b1;
        alloc_size  = CNT_W'(size);
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 1'b0;
        lat = 1;
        busy_bad = 0;
        while (!rsp_valid && lat < 400) begin
            if (alloc_ready || free_ready || flush_ready) busy_bad++;
            @(negedge clk);
            lat++;
        end
        chk(rsp_valid == 1'b1, req, int'(rsp_valid), 1);
        chk(rsp_fail == xfail, req, int'(rsp_fail), int'(xfail));
        chk(int'(rsp_offset) == xoff, req, int'(rsp_offset), xoff);
        chk(busy_bad == 0, "R10 ready during scan", busy_bad, 0);
        if (xlat > 0) chk(lat == xlat, "R10 latency", lat, xlat);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R3 single strobe", int'(rsp_valid), 0);
    endtask

    task automatic do_free(input int off, input int size);
        @(negedge clk);
        chk(free_ready == 1'b1, "R10 free ready", int'(free_ready), 1);
        free_valid  = 1'b1;
        free_offset = IDX_W'(off);
        free_size   = CNT_W'(size);
        @(posedge clk);
        @(negedge clk);
        free_valid = 1'b0;
    endtask

    task automatic do_flush(input int xpulse, input string req);
        @(negedge clk);
        flush_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush_valid = 1'b0;
        chk(int'(flush_pulse) == xpulse, req, int'(flush_pulse), xpulse);
        @(negedge clk);
        chk(flush_pulse == 1'b0, "R9 single pulse", int'(flush_pulse), 0);
    endtask

    task automatic chk_pages(input int off, input int len, input int xp);
        calc_off = PS'(off);
        calc_len = LW'(len);
        #1;
        chk(int'(calc_pages) == xp, "R11 page count", int'(calc_pages), xp);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state at the ports
        chk(alloc_ready == 1'b1 && free_ready == 1'b1 && flush_ready == 1'b1,
            "R1 readies", int'({alloc_ready, free_ready, flush_ready}), 7);
        chk(rsp_valid == 1'b0 && flush_pulse == 1'b0, "R1 outputs idle",
            int'({rsp_valid, flush_pulse}), 0);

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_ALLOC: do_alloc(int'(TBL[i].a), "R2/R3 table alloc", TBL[i].xfail,
                                   (TBL[i].xfail ? FAILOFF : int'(TBL[i].xval)), 0);
                OP_FREE:  do_free(int'(TBL[i].a), int'(TBL[i].b));
                default:  do_flush(int'(TBL[i].xval), "R9 table flush");
            endcase
        end

        // R7 strict mode: success without wrap or retry still raises the flag
        full_flush = 1'b1;
        do_alloc(1, "R7 strict alloc", 1'b0, 43, 0);
        do_flush(1, "R7 strict success flag");
        do_alloc(0, "R7 strict zero-size", 1'b1, FAILOFF, 0);
        do_flush(1, "R7 strict failure flag");
        full_flush = 1'b0;

        // R1 fresh reset: first grant and exact scan latency (32 reserved + 4 examined)
        do_reset();
        do_flush(0, "R1 flag clear");
        do_alloc(4, "R1 first grant", 1'b0, 32, RSV + 4 + 1);

        // R10 priority: all three commands at once, only allocate is ready
        @(negedge clk);
        alloc_valid = 1'b1; alloc_size = CNT_W'(1);
        free_valid = 1'b1; free_offset = '0; free_size = CNT_W'(1);
        flush_valid = 1'b1;
        #1;
        chk(alloc_ready == 1'b1, "R10 alloc wins", int'(alloc_ready), 1);
        chk(free_ready == 1'b0, "R10 free held", int'(free_ready), 0);
        chk(flush_ready == 1'b0, "R10 flush held", int'(flush_ready), 0);
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 1'b0; free_valid = 1'b0; flush_valid = 1'b0;
        begin
            int w = 0;
            while (!rsp_valid && w < 400) begin
                @(negedge clk);
                w++;
            end
        end
        chk(rsp_valid == 1'b1 && rsp_fail == 1'b0, "R10 priority grant",
            int'({rsp_valid, rsp_fail}), 2);
        chk(int'(rsp_offset) == 36, "R2 grant after priority", int'(rsp_offset), 36);

        // R11 page-count helper
        chk_pages(0, 4096, 1);
        chk_pages(1, 4096, 2);
        chk_pages(4095, 1, 1);
        chk_pages(4095, 2, 2);
        chk_pages(0, 0, 0);
        chk_pages(100, 8192, 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule